// File: doc/BRIEF.md
# All-Frame Mode Counter Controller

This block decides whether a paging receiver's frame decoder has to work on every frame rather than only on its own scheduled frames. It keeps a bank of small counters, one for each temporary address, plus a single all-frame counter and a force flag. The decoder side raises a counter when it sees a matching event. For a temporary address, that event is a short instruction vector that assigns the address. Only the host can lower a counter, and it does so with command packets. A single command packet can lower any selection of counters by one. It can also write the force flag.

The mode output is high while any counter is non-zero or the force flag is set. At each frame end seen while the mode is high, the block raises a one-cycle request for an end-of-frame status packet. Increments stop at the counter ceiling and decrements stop at zero. When an increment and a decrement reach the same counter in the same cycle, they cancel.

Top module: `allframe_ctrl`

## Requirements
- R1: While the reset input is low, `all_frame_en` and `eof_req` are 0. After reset every counter is 0 and the force flag is clear.
- R2: A cycle with `tmp_inc_vld` high and no command adds one to the counter selected by `tmp_inc_idx`. `all_frame_en` is 1 from the next cycle on.
- R3: A cycle with `afc_inc` high and no command adds one to the all-frame counter. `all_frame_en` is 1 from the next cycle on.
- R4: A cycle with `cmd_vld` high subtracts exactly one from each temporary counter whose bit is set in `cmd_tmp_dec` (bit i selects counter i). It also subtracts one from the all-frame counter when `cmd_afc_dec` is 1. A counter raised N times therefore needs N decrements before it reads zero.
- R5: Counters are CNT_W bits wide (4 by default) and stop at 15. After 16 or more increments, exactly 15 decrements bring a counter back to zero.
- R6: A decrement of a counter already at zero leaves it at zero.
- R7: An increment and a decrement of the same counter in the same cycle leave that counter unchanged.
- R8: A command with `cmd_force_wr` = 1 loads `cmd_force_val` into the force flag. A set flag holds `all_frame_en` at 1 on its own.
- R9: `all_frame_en` is the OR of "some counter is non-zero" and the force flag, updated one cycle after the strobe that changes it.
- R10: A `frame_end` pulse sampled while `all_frame_en` is 1 gives `eof_req` = 1 for exactly the next cycle. With the mode off, `frame_end` gives no request.
- R11: Decrement and force fields presented while `cmd_vld` is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tmp_inc_vld | input | 1 | Temporary-address increment strobe |
| tmp_inc_idx | input | IDX_W | Index of the temporary counter to increment |
| afc_inc | input | 1 | All-frame counter increment strobe |
| cmd_vld | input | 1 | Host command packet strobe |
| cmd_tmp_dec | input | TMP_N | Per-counter decrement mask, bit i selects counter i |
| cmd_afc_dec | input | 1 | Decrement the all-frame counter |
| cmd_force_wr | input | 1 | Write the force flag |
| cmd_force_val | input | 1 | Value written to the force flag |
| frame_end | input | 1 | End-of-frame strobe |
| all_frame_en | output | 1 | All-frame mode active |
| eof_req | output | 1 | One-cycle end-of-frame status request |

## Verification
The mode is driven up through each of its three sources in turn: a temporary counter, the all-frame counter and the force flag. Each source is then brought back down on its own, which shows that none of them masks another.

Several input patterns separate correct counting from near misses:
- Two increments followed by decrements one at a time tell real counting apart from a simple set/clear flag.
- A decrement at zero followed by one increment and one decrement exposes wrap-around.
- A multi-bit decrement mask shows that every selected counter moves.
- Long runs of increments past the ceiling check saturation.
- Same-cycle increment and decrement of one counter checks the cancel rule.
- Command fields presented without the strobe check that they are ignored.
- Frame-end pulses with the mode on and off check the status request.

// File: rtl/allframe_pkg.sv
package allframe_pkg;
  parameter int TMP_N_DEF = 16;
  parameter int CNT_W_DEF = 4;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_UP   = 2'd1,
    CNT_DOWN = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/afm_rst_sync.sv
module afm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/afm_sat_cnt.sv
module afm_sat_cnt
  import allframe_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             nz
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  cnt_op_e          op;

  always_comb begin
    op = CNT_HOLD;
    if (inc && !dec && cnt_q != CNT_MAX)            op = CNT_UP;
    else if (dec && !inc && cnt_q != '0)            op = CNT_DOWN;
  end

  always_comb begin
    unique case (op)
      CNT_UP:   cnt_d = cnt_q + 1'b1;
      CNT_DOWN: cnt_d = cnt_q - 1'b1;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (op != CNT_HOLD)  cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
  assign nz  = |cnt_q;
endmodule

// File: rtl/afm_status.sv
module afm_status #(
  parameter int SRC_N = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] cnt_nz,
  input  logic             force_wr,
  input  logic             force_val,
  input  logic             frame_end,
  output logic             mode_en,
  output logic             eof_req
);
  logic force_q, force_d;
  logic eof_q, eof_d;

  always_comb begin
    force_d = force_wr ? force_val : force_q;
    mode_en = force_q | (|cnt_nz);
    eof_d   = frame_end & mode_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_q <= 1'b0;
      eof_q   <= 1'b0;
    end else begin
      if (force_wr) force_q <= force_d;
      eof_q <= eof_d;
    end
  end

  assign eof_req = eof_q;
endmodule

// File: rtl/allframe_ctrl.sv
module allframe_ctrl
  import allframe_pkg::*;
#(
  parameter int TMP_N = TMP_N_DEF,
  parameter int CNT_W = CNT_W_DEF,
  parameter int IDX_W = $clog2(TMP_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmp_inc_vld,
  input  logic [IDX_W-1:0] tmp_inc_idx,
  input  logic             afc_inc,
  input  logic             cmd_vld,
  input  logic [TMP_N-1:0] cmd_tmp_dec,
  input  logic             cmd_afc_dec,
  input  logic             cmd_force_wr,
  input  logic             cmd_force_val,
  input  logic             frame_end,
  output logic             all_frame_en,
  output logic             eof_req
);
  localparam int SRC_N = TMP_N + 1;

  logic             rst_i_n;
  logic [TMP_N-1:0] tmp_inc_hot;
  logic [TMP_N-1:0] tmp_dec_hot;
  logic [SRC_N-1:0] src_nz;

  afm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  always_comb begin
    tmp_inc_hot = '0;
    if (tmp_inc_vld) tmp_inc_hot[tmp_inc_idx] = 1'b1;
    tmp_dec_hot = cmd_vld ? cmd_tmp_dec : '0;
  end

  for (genvar g = 0; g < TMP_N; g++) begin : g_tmp
    logic [CNT_W-1:0] cnt_unused;
    afm_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_i_n),
      .inc   (tmp_inc_hot[g]),
      .dec   (tmp_dec_hot[g]),
      .cnt   (cnt_unused),
      .nz    (src_nz[g])
    );
  end

  logic [CNT_W-1:0] afc_cnt_unused;
  afm_sat_cnt #(.CNT_W(CNT_W)) u_afc (
    .clk   (clk),
    .rst_n (rst_i_n),
    .inc   (afc_inc),
    .dec   (cmd_vld & cmd_afc_dec),
    .cnt   (afc_cnt_unused),
    .nz    (src_nz[TMP_N])
  );

  afm_status #(.SRC_N(SRC_N)) u_stat (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .cnt_nz    (src_nz),
    .force_wr  (cmd_vld & cmd_force_wr),
    .force_val (cmd_force_val),
    .frame_end (frame_end),
    .mode_en   (all_frame_en),
    .eof_req   (eof_req)
  );
endmodule

// File: rtl/allframe_ctrl_chk.sv
module allframe_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic tmp_inc_vld,
  input logic afc_inc,
  input logic cmd_vld,
  input logic cmd_force_wr,
  input logic cmd_force_val,
  input logic frame_end,
  input logic all_frame_en,
  input logic eof_req
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> (!all_frame_en && !eof_req)); // R1
  AST_TMP_INC_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (tmp_inc_vld && !cmd_vld) |=> all_frame_en); // R2
  AST_AFC_INC_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (afc_inc && !cmd_vld) |=> all_frame_en); // R3
  AST_FORCE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_force_wr && cmd_force_val) |=> all_frame_en); // R8
  AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(all_frame_en) |-> $past(tmp_inc_vld || afc_inc || (cmd_vld && cmd_force_wr && cmd_force_val))); // R9
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmp_inc_vld && !afc_inc && !cmd_vld) |=> $stable(all_frame_en)); // R11
  AST_EOF_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && all_frame_en) |=> eof_req); // R10
  AST_EOF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_end && all_frame_en) |=> !eof_req); // R10
endmodule

bind allframe_ctrl allframe_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tmp_inc_vld   (tmp_inc_vld),
  .afc_inc       (afc_inc),
  .cmd_vld       (cmd_vld),
  .cmd_force_wr  (cmd_force_wr),
  .cmd_force_val (cmd_force_val),
  .frame_end     (frame_end),
  .all_frame_en  (all_frame_en),
  .eof_req       (eof_req)
);

// File: tb/sim_allframe_ctrl.sv
`timescale 1ns/1ps
module sim_allframe_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        tmp_inc_vld = 1'b0;
  logic [3:0]  tmp_inc_idx = '0;
  logic        afc_inc = 1'b0;
  logic        cmd_vld = 1'b0;
  logic [15:0] cmd_tmp_dec = '0;
  logic        cmd_afc_dec = 1'b0;
  logic        cmd_force_wr = 1'b0;
  logic        cmd_force_val = 1'b0;
  logic        frame_end = 1'b0;
  logic        all_frame_en;
  logic        eof_req;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_cnt = 0;

  always #10 clk = ~clk;

  allframe_ctrl u0 (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic        ti;
    logic [3:0]  idx;
    logic        ai;
    logic        cv;
    logic [15:0] mask;
    logic        ad;
    logic        fw;
    logic        fv;
    logic        fe;
    logic        een;
    logic        eeof;
  } vec_t;

  function automatic vec_t v(int rq, bit ti, int idx, bit ai, bit cv, int mask,
                             bit ad, bit fw, bit fv, bit fe, bit een, bit eeof);
    vec_t r;
    r.req = 4'(rq); r.ti = ti; r.idx = 4'(idx); r.ai = ai; r.cv = cv;
    r.mask = 16'(mask); r.ad = ad; r.fw = fw; r.fv = fv; r.fe = fe;
    r.een = een; r.eeof = eeof;
    return r;
  endfunction

  localparam int NV = 28;
  //                       rq ti idx ai cv mask     ad fw fv fe en eof
  localparam vec_t TBL [NV] = '{
    v(10, 0, 0, 0, 0, 'h0000, 0, 0, 0, 1, 0, 0), // R10 no request with mode off
    v( 2, 1, 5, 0, 0, 'h0000, 0, 0, 0, 0, 1, 0), // R2
    v(10, 0, 0, 0, 0, 'h0000, 0, 0, 0, 1, 1, 1), // R10
    v( 4, 0, 0, 0, 1, 'h0020, 0, 0, 0, 0, 0, 0), // R4
    v(10, 0, 0, 0, 0, 'h0000, 0, 0, 0, 1, 0, 0), // R10
    v( 3, 0, 0, 1, 0, 'h0000, 0, 0, 0, 0, 1, 0), // R3
    v( 4, 0, 0, 0, 1, 'h0000, 1, 0, 0, 0, 0, 0), // R4
    v( 8, 0, 0, 0, 1, 'h0000, 0, 1, 1, 0, 1, 0), // R8
    v(10, 0, 0, 0, 0, 'h0000, 0, 0, 0, 1, 1, 1), // R10
    v( 8, 0, 0, 0, 1, 'h0000, 0, 1, 0, 0, 0, 0), // R8
    v( 2, 1,15, 0, 0, 'h0000, 0, 0, 0, 0, 1, 0), // R2
    v( 2, 1,15, 0, 0, 'h0000, 0, 0, 0, 0, 1, 0), // R2
    v( 4, 0, 0, 0, 1, 'h8000, 0, 0, 0, 0, 1, 0), // R4 one of two
    v( 4, 0, 0, 0, 1, 'h8000, 0, 0, 0, 0, 0, 0), // R4
    v( 6, 0, 0, 0, 1, 'h8000, 0, 0, 0, 0, 0, 0), // R6 dec at zero
    v( 6, 1,15, 0, 0, 'h0000, 0, 0, 0, 0, 1, 0), // R6
    v( 6, 0, 0, 0, 1, 'h8000, 0, 0, 0, 0, 0, 0), // R6 no wrap
    v(11, 1, 0, 0, 0, 'h0000, 0, 0, 0, 0, 1, 0), // R11 setup
    v(11, 0, 0, 0, 0, 'h0001, 1, 1, 1, 0, 1, 0), // R11 fields without strobe
    v(11, 0, 0, 0, 1, 'h0001, 0, 0, 0, 0, 0, 0), // R11 force never set
    v( 7, 1, 2, 0, 1, 'h0004, 0, 0, 0, 0, 0, 0), // R7 at zero
    v( 7, 1, 2, 0, 0, 'h0000, 0, 0, 0, 0, 1, 0), // R7
    v( 7, 1, 2, 0, 1, 'h0004, 0, 0, 0, 0, 1, 0), // R7 cancel
    v( 7, 0, 0, 0, 1, 'h0004, 0, 0, 0, 0, 0, 0), // R7
    v( 9, 1, 1, 0, 0, 'h0000, 0, 0, 0, 0, 1, 0), // R9
    v( 9, 1, 9, 1, 0, 'h0000, 0, 0, 0, 0, 1, 0), // R9
    v( 4, 0, 0, 0, 1, 'h0202, 0, 0, 0, 0, 1, 0), // R4 mask clears both, afc left
    v( 9, 0, 0, 0, 1, 'h0000, 1, 0, 0, 1, 0, 1)  // R9 R10
  };

  task automatic check(input int rq, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual=%b expected=%b", rq, what, act, exp);
    end
  endtask

  task automatic idle();
    tmp_inc_vld = 0; afc_inc = 0; cmd_vld = 0; cmd_tmp_dec = '0;
    cmd_afc_dec = 0; cmd_force_wr = 0; cmd_force_val = 0; frame_end = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic inc_tmp(input int idx);
    tmp_inc_vld = 1; tmp_inc_idx = 4'(idx); step(); idle();
  endtask

  task automatic dec_tmp(input int idx);
    cmd_vld = 1; cmd_tmp_dec = 16'(1 << idx); step(); idle();
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 0;
    @(negedge clk); @(negedge clk);
    check(1, "en in reset", all_frame_en, 1'b0);   // R1
    check(1, "eof in reset", eof_req, 1'b0);       // R1
    rst_n = 1;
    repeat (4) step();
    check(1, "en after reset", all_frame_en, 1'b0); // R1

    for (int i = 0; i < NV; i++) begin
      tmp_inc_vld = TBL[i].ti; tmp_inc_idx = TBL[i].idx; afc_inc = TBL[i].ai;
      cmd_vld = TBL[i].cv; cmd_tmp_dec = TBL[i].mask; cmd_afc_dec = TBL[i].ad;
      cmd_force_wr = TBL[i].fw; cmd_force_val = TBL[i].fv; frame_end = TBL[i].fe;
      step();
      check(int'(TBL[i].req), $sformatf("vec %0d en", i), all_frame_en, TBL[i].een);
      check(int'(TBL[i].req), $sformatf("vec %0d eof", i), eof_req, TBL[i].eeof);
      idle();
    end

    // R5 temporary counter saturation
    for (int k = 0; k < 20; k++) inc_tmp(7);
    for (int k = 0; k < 14; k++) dec_tmp(7);
    check(5, "tmp after 14 dec", all_frame_en, 1'b1);
    dec_tmp(7);
    check(5, "tmp after 15 dec", all_frame_en, 1'b0);

    // R5 all-frame counter saturation
    for (int k = 0; k < 17; k++) begin afc_inc = 1; step(); idle(); end
    for (int k = 0; k < 14; k++) begin cmd_vld = 1; cmd_afc_dec = 1; step(); idle(); end
    check(5, "afc after 14 dec", all_frame_en, 1'b1);
    cmd_vld = 1; cmd_afc_dec = 1; step(); idle();
    check(5, "afc after 15 dec", all_frame_en, 1'b0);

    // R10 pulse lasts one cycle
    inc_tmp(3);
    frame_end = 1; step(); idle();
    check(10, "eof pulse", eof_req, 1'b1);
    step();
    check(10, "eof one cycle", eof_req, 1'b0);

    // R1 reset clears counters and force
    cmd_vld = 1; cmd_force_wr = 1; cmd_force_val = 1; step(); idle();
    rst_n = 0; #2;
    check(1, "en async clear", all_frame_en, 1'b0);
    step(); rst_n = 1; repeat (4) step();
    check(1, "en after mid reset", all_frame_en, 1'b0);
    frame_end = 1; step(); idle();
    check(1, "eof after mid reset", eof_req, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule